// File: doc/BRIEF.md
# Sliding Window Operand Register Bank

This block holds the two square operand windows, A and B, that feed the elementwise stage of a window-based image pipeline. All 2·N² registers are presented in parallel on two flat output buses, so the next stage sees every element of both windows in the same cycle. Pixels arrive one per cycle from a memory port. Which addresses are read from that memory is decided elsewhere.

Window A is filled one column at a time. A command either loads a whole window (N columns) or loads a single new column. In both cases each completed column moves the existing columns one place to the left and places the new column at the right edge. This lets the window slide one pixel along a row with only N reads, and the N·(N−1) values already held are kept. A partially received column is held in a staging register and never shows on the A bus. Window B is either loaded once and then held for any number of A steps, or switched to take a feedback window from later in the pipeline, so that it works as an accumulator.

A one-cycle `window_ready` pulse is raised in the same cycle that a finished A command makes a complete window visible. For the pipeline never to wait, the pixel rate must be N times the window rate.

Top module: `slide_win_bank`

## Requirements
- R1: After reset every A and B element reads zero, `window_ready` is low, and B takes no feedback.
- R2: Command code 2'b00 loads a full A window from N² accepted pixels. The leftmost column comes first, and each column is sent top row first. Element (row r, column c) sits at bits [(r·N+c)·DW +: DW] of `a_win`. The cycle after the last pixel, A holds exactly these values.
- R3: Command code 2'b01 accepts N pixels, top row first. On the last pixel every A column moves one place left (the leftmost is dropped), and the new column lands in column N−1. All other values are kept.
- R4: A does not change until the last pixel of a column has been accepted, and `window_ready` is never raised while a column is incomplete.
- R5: `window_ready` is high for exactly one cycle, in the cycle after a load or shift command's last pixel, and only if at least N columns have been completed since reset. After reset, shifts alone first raise it on the Nth shift.
- R6: Command code 2'b10 writes N² accepted pixels into B in row-major order, top row first. Pixel k goes to bits [k·DW +: DW] of `b_win`. This command also turns feedback off. B then stays unchanged through any number of A commands.
- R7: Command code 2'b11 sets the B source from `cmd_arg`: 1 selects feedback and 0 selects hold. While feedback is selected, every cycle with `q_valid` high copies `q_data` into B by the next cycle. Otherwise `q_data` has no effect on B.
- R8: A command presented while a load is in progress is ignored. A pixel presented while no load is in progress is ignored and is not counted toward a later load. Pixel gaps (`pix_valid` low) inside a load only pause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_op | input | 2 | 00 load A, 01 shift A column, 10 load B, 11 set B source |
| cmd_arg | input | 1 | B source for op 11: 1 feedback, 0 hold |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | DW | Pixel value |
| q_valid | input | 1 | Feedback window strobe |
| q_data | input | N·N·DW | Feedback window, row-major |
| a_win | output | N·N·DW | Window A, element (r,c) at (r·N+c)·DW |
| b_win | output | N·N·DW | Window B, row-major |
| window_ready | output | 1 | One-cycle pulse: complete A window just made visible |

## Verification
The bench builds the block with N = 3 and DW = 8. This is small enough that every A element, every B element and the column counter's saturation at three can be followed by hand against a model held in arrays. A three-pixel column makes both the staging path and the direct last-row path show up in each shift. A sweep slides the window across an eight-column strip under two value seeds. Other sequences cover shifts from reset before any full load, commands and pixels presented at the wrong time, a pixel gap inside a load, and switching B between feedback, hold and reload.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_A  = 2'b00,
    OP_SHIFT_A = 2'b01,
    OP_LOAD_B  = 2'b10,
    OP_B_SRC   = 2'b11
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LDA  = 2'b01,
    ST_LDB  = 2'b10
  } st_t;

  // flat element number of (row, col) in an n-wide window
  function automatic int elem_num(input int r, input int c, input int n);
    return r * n + c;
  endfunction

  // next value of a counter that stops at lim
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/swb_ctrl.sv
module swb_ctrl import swb_pkg::*; #(
  parameter int N  = 3,
  parameter int RW = 2,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_arg,
  input  logic          pix_valid,
  output logic          a_wr,
  output logic          a_shift,
  output logic [RW-1:0] a_row,
  output logic          b_wr,
  output logic [BW-1:0] b_idx,
  output logic          fb_sel,
  output logic          window_ready
);
  localparam int NN = N * N;
  localparam int CW = $clog2(N + 1);

  st_t           state;
  logic [CW-1:0] cols_left;
  logic [CW-1:0] cols_seen;
  logic          a_cmd_done;
  logic          idle_cmd;

  assign idle_cmd   = cmd_valid && (state == ST_IDLE);
  assign a_wr       = (state == ST_LDA) && pix_valid;
  assign a_shift    = a_wr && (a_row == RW'(N - 1));
  assign a_cmd_done = a_shift && (cols_left == '0);
  assign b_wr       = (state == ST_LDB) && pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cols_left    <= '0;
      cols_seen    <= '0;
      a_row        <= '0;
      b_idx        <= '0;
      fb_sel       <= 1'b0;
      window_ready <= 1'b0;
    end else begin
      window_ready <= a_cmd_done &&
                      (sat_inc(int'(cols_seen), N) >= N);
      if (a_shift)
        cols_seen <= CW'(sat_inc(int'(cols_seen), N));
      case (state)
        ST_IDLE: if (idle_cmd) begin
          case (op_t'(cmd_op))
            OP_LOAD_A:  begin state <= ST_LDA; cols_left <= CW'(N - 1); a_row <= '0; end
            OP_SHIFT_A: begin state <= ST_LDA; cols_left <= '0;         a_row <= '0; end
            OP_LOAD_B:  begin state <= ST_LDB; b_idx <= '0; fb_sel <= 1'b0; end
            default:    fb_sel <= cmd_arg;
          endcase
        end
        ST_LDA: if (a_wr) begin
          if (a_shift) begin
            a_row <= '0;
            if (cols_left == '0) state <= ST_IDLE;
            else cols_left <= cols_left - 1'b1;
          end else begin
            a_row <= a_row + 1'b1;
          end
        end
        ST_LDB: if (b_wr) begin
          if (b_idx == BW'(NN - 1)) state <= ST_IDLE;
          else b_idx <= b_idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_ready |-> (state == ST_IDLE));
  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_wr, b_wr}));
  // R8
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LDB && cmd_valid && !b_wr) |=> (state == ST_LDB));
endmodule

// File: rtl/swb_abank.sv
module swb_abank import swb_pkg::*; #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int RW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_shift,
  input  logic [RW-1:0]     a_row,
  input  logic [DW-1:0]     pix,
  output logic [N*N*DW-1:0] a_flat
);
  logic [DW-1:0] a_q   [N][N];
  logic [DW-1:0] stage [N];
  logic [DW-1:0] col_in[N];

  always_comb begin
    for (int r = 0; r < N; r++)
      col_in[r] = (r == N - 1) ? pix : stage[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        stage[r] <= '0;
        for (int c = 0; c < N; c++) a_q[r][c] <= '0;
      end
    end else if (a_shift) begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N - 1; c++) a_q[r][c] <= a_q[r][c+1];
        a_q[r][N-1] <= col_in[r];
      end
    end else if (a_wr) begin
      stage[a_row] <= pix;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign a_flat[elem_num(r, c, N)*DW +: DW] = a_q[r][c];
    end
  end

  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_shift |=> $stable(a_flat));
  // R3
  a_newpix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_shift |=> (a_q[N-1][N-1] == $past(pix)));
  if (N > 1) begin : g_reuse
    // R3
    a_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_shift |=> (a_q[0][0] == $past(a_q[0][1])));
  end
endmodule

// File: rtl/swb_bbank.sv
module swb_bbank #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_wr,
  input  logic [BW-1:0]     b_idx,
  input  logic [DW-1:0]     pix,
  input  logic              fb_sel,
  input  logic              q_valid,
  input  logic [N*N*DW-1:0] q_data,
  output logic [N*N*DW-1:0] b_flat
);
  localparam int NN = N * N;

  logic [DW-1:0] b_q [NN];
  logic          fb_take;

  assign fb_take = fb_sel && q_valid && !b_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NN; k++) b_q[k] <= '0;
    end else if (b_wr) begin
      b_q[b_idx] <= pix;
    end else if (fb_take) begin
      for (int k = 0; k < NN; k++) b_q[k] <= q_data[k*DW +: DW];
    end
  end

  for (genvar k = 0; k < NN; k++) begin : g_el
    assign b_flat[k*DW +: DW] = b_q[k];
  end

  // R7
  b_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_take |=> (b_flat == $past(q_data)));
  // R6
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_wr && !(fb_sel && q_valid)) |=> $stable(b_flat));
endmodule

// File: rtl/slide_win_bank.sv
module slide_win_bank #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_arg,
  input  logic              pix_valid,
  input  logic [DW-1:0]     pix_data,
  input  logic              q_valid,
  input  logic [N*N*DW-1:0] q_data,
  output logic [N*N*DW-1:0] a_win,
  output logic [N*N*DW-1:0] b_win,
  output logic              window_ready
);
  localparam int NN = N * N;
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam int BW = (NN > 1) ? $clog2(NN) : 1;

  logic          a_wr, a_shift, b_wr, fb_sel;
  logic [RW-1:0] a_row;
  logic [BW-1:0] b_idx;

  swb_ctrl #(.N(N), .RW(RW), .BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .pix_valid(pix_valid), .a_wr(a_wr), .a_shift(a_shift),
    .a_row(a_row), .b_wr(b_wr), .b_idx(b_idx), .fb_sel(fb_sel),
    .window_ready(window_ready));

  swb_abank #(.N(N), .DW(DW), .RW(RW)) u_abank (
    .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_shift(a_shift), .a_row(a_row),
    .pix(pix_data), .a_flat(a_win));

  swb_bbank #(.N(N), .DW(DW), .BW(BW)) u_bbank (
    .clk(clk), .rst_n(rst_n), .b_wr(b_wr), .b_idx(b_idx), .pix(pix_data),
    .fb_sel(fb_sel), .q_valid(q_valid), .q_data(q_data), .b_flat(b_win));
endmodule

// File: tb/slide_win_bank_test.sv
module slide_win_bank_test;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int WB = N * N * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic          cmd_arg = 1'b0;
  logic          pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic          q_valid = 1'b0;
  logic [WB-1:0] q_data = '0;
  logic [WB-1:0] a_win, b_win;
  logic          window_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ea[N][N];
  int eb[N*N];
  int seen = 0;

  slide_win_bank #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .pix_valid(pix_valid), .pix_data(pix_data),
    .q_valid(q_valid), .q_data(q_data), .a_win(a_win), .b_win(b_win),
    .window_ready(window_ready));

  always #5 clk = ~clk;

  function automatic logic [WB-1:0] pack_a();
    logic [WB-1:0] v = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) v[(r*N+c)*DW +: DW] = DW'(ea[r][c]);
    return v;
  endfunction

  function automatic logic [WB-1:0] pack_b();
    logic [WB-1:0] v = '0;
    for (int k = 0; k < N*N; k++) v[k*DW +: DW] = DW'(eb[k]);
    return v;
  endfunction

  function automatic int pv(input int seed, input int r, input int c);
    return (r * 37 + c * 11 + seed * 53 + 5) & 255;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic arg);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pix(input int v);
    pix_valid = 1'b1; pix_data = DW'(v);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // one column into A, top row first; the model shifts when it completes
  task automatic send_col(input int seed, input int c, input bit last, input string req);
    for (int r = 0; r < N; r++) begin
      pix(pv(seed, r, c));
      if (r < N - 1) begin
        chk("R4", "A mid-column", a_win, pack_a());
        chk("R4", "ready mid-column", {{(WB-1){1'b0}}, window_ready}, '0);
      end
    end
    for (int r = 0; r < N; r++) begin
      for (int k = 0; k < N - 1; k++) ea[r][k] = ea[r][k+1];
      ea[r][N-1] = pv(seed, r, c);
    end
    seen = (seen >= N) ? N : seen + 1;
    chk(req, "A after column", a_win, pack_a());
    chk("R5", "ready after column", {{(WB-1){1'b0}}, window_ready},
        {{(WB-1){1'b0}}, (last && seen >= N)});
  endtask

  task automatic shift_a(input int seed, input int c);
    cmd(2'b01, 1'b0);
    send_col(seed, c, 1'b1, "R3");
  endtask

  task automatic full_a(input int seed, input int c0);
    cmd(2'b00, 1'b0);
    for (int c = 0; c < N; c++) send_col(seed, c0 + c, c == N - 1, "R2");
  endtask

  task automatic load_b(input int seed);
    cmd(2'b10, 1'b0);
    for (int k = 0; k < N*N; k++) begin
      pix((k * 29 + seed * 7 + 3) & 255);
      eb[k] = (k * 29 + seed * 7 + 3) & 255;
    end
    chk("R6", "B after load", b_win, pack_b());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) ea[r][c] = 0;
    for (int k = 0; k < N*N; k++) eb[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "A reset", a_win, '0);
    chk("R1", "B reset", b_win, '0);
    chk("R1", "ready reset", {{(WB-1){1'b0}}, window_ready}, '0);
    q_valid = 1'b1; q_data = {WB{1'b1}};
    @(negedge clk);
    q_valid = 1'b0;
    chk("R1", "no feedback after reset", b_win, '0);

    // R5 shifts from reset: ready only on the Nth
    for (int c = 0; c < N; c++) shift_a(1, c);
    @(negedge clk);
    chk("R5", "ready one cycle", {{(WB-1){1'b0}}, window_ready}, '0);

    // R2 full loads, then sweep with shifts across an 8-wide strip
    for (int s = 2; s < 4; s++) begin
      full_a(s, 0);
      for (int c = N; c < 8; c++) shift_a(s, c);
    end

    // R6 B load, held across A commands
    load_b(5);
    for (int c = 8; c < 10; c++) shift_a(4, c);
    full_a(6, 0);
    chk("R6", "B held", b_win, pack_b());

    // R8 command during an A load is ignored; a gap only pauses
    cmd(2'b00, 1'b0);
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) begin
        if (c == 1 && r == 1) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
        pix(pv(7, r, c));
        cmd_valid = 1'b0;
        if (c == 0 && r == 0) @(negedge clk);
      end
      for (int r = 0; r < N; r++) begin
        for (int k = 0; k < N - 1; k++) ea[r][k] = ea[r][k+1];
        ea[r][N-1] = pv(7, r, c);
      end
    end
    chk("R8", "A after busy cmd", a_win, pack_a());
    chk("R8", "B untouched by busy cmd", b_win, pack_b());
    // R8 idle pixels ignored
    for (int i = 0; i < N; i++) pix(200 + i);
    chk("R8", "A idle pixels", a_win, pack_a());
    chk("R8", "B idle pixels", b_win, pack_b());
    shift_a(8, 0);

    // R7 feedback source
    q_valid = 1'b1; q_data = {WB{1'b1}} ^ pack_b();
    @(negedge clk);
    q_valid = 1'b0;
    chk("R7", "q ignored in hold", b_win, pack_b());
    cmd(2'b11, 1'b1);
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < N*N; k++) eb[k] = (k * 13 + i * 41 + 1) & 255;
      q_valid = 1'b1; q_data = pack_b();
      @(negedge clk);
      chk("R7", "B follows q", b_win, pack_b());
    end
    q_valid = 1'b0; q_data = '0;
    @(negedge clk);
    chk("R7", "B held without q_valid", b_win, pack_b());
    cmd(2'b11, 1'b0);
    q_valid = 1'b1; q_data = {WB{1'b1}};
    @(negedge clk);
    q_valid = 1'b0;
    chk("R7", "q ignored after hold select", b_win, pack_b());
    // R6 load B turns feedback off
    cmd(2'b11, 1'b1);
    load_b(9);
    q_valid = 1'b1; q_data = {WB{1'b1}};
    @(negedge clk);
    q_valid = 1'b0;
    chk("R6", "feedback off after B load", b_win, pack_b());

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule